// File: doc/BRIEF.md
# Dual-Clock FIFO with Read Rewind

This block is a 512-entry, 9-bit first-in first-out buffer placed between two clock domains. A producer pushes one word on each write-clock edge while its active-low write enable is held low. A consumer pulls one word on each read-clock edge while its active-low read enable is held low. The two clocks may be the same net or fully unrelated. Each read loads the fetched word into an output register. A separate output enable either drives that register onto the data pins or leaves the pins floating.

The write pointer and the read pointer cross between the domains as Gray codes through two-stage synchronizers. Empty and almost-empty are derived in the read domain. Full, half-full and almost-full are derived in the write domain. One threshold register, written from the write side, sets both almost flags. An active-low rewind input returns the read pointer to the position it held at the last reset, so that the data written since that reset can be read a second time.

Top module: `retx_fifo`

## Requirements
- R1: Words leave the buffer in the order they were accepted, when the write and read clocks run at different rates. A write is accepted on a write-clock rising edge with `wr_en_n` low and `full` low. A read is performed on a read-clock rising edge with `rd_en_n` low, `empty` low and `rew_n` high. After a read, `q` shows the word from the next rising edge of `rd_clk`.
- R2: A write while `full` is high changes neither the stored data nor the write pointer. A read while `empty` is high does not move the read pointer. In both cases the later read data show no gap and no overwrite.
- R3: `full` is high exactly when 512 words are held, and `empty` is high exactly when no word is held. Each flag is judged on its own domain's view of the other pointer.
- R4: `half_full` is high when the write-domain word count is 256 or more, and low at 255 or fewer.
- R5: `almost_empty` is high when the read-domain word count is at or below the threshold. `almost_full` is high when the write-domain free space (512 minus count) is at or below the threshold. After reset the threshold is 64.
- R6: When `thr_ld` is high on a write-clock rising edge, the threshold takes the value of `thr_val`, an unsigned 9-bit number. Both almost flags use the new value from then on.
- R7: When `rew_n` is low on a read-clock rising edge, the read pointer returns to zero, which is its position at the last reset. The next reads replay the words in the order they were written since that reset. This applies only if no more than 512 words have been written since that reset.
- R8: While `out_en` is low, `q` is high-impedance. While `out_en` is high, `q` drives the output register, which holds its value on every read-clock edge without a read.
- R9: A synchronous active-high `rst`, held for several edges of both clocks, empties the buffer and clears the output register to 0. It leaves `empty` and `almost_empty` high and `full`, `half_full` and `almost_full` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen in both domains |
| wr_en_n | input | 1 | Active-low write request |
| din | input | 9 | Word to store |
| rd_en_n | input | 1 | Active-low read request |
| rew_n | input | 1 | Active-low rewind of the read pointer |
| out_en | input | 1 | High drives `q`, low floats it |
| thr_ld | input | 1 | Loads the almost-flag threshold (write clock) |
| thr_val | input | 9 | New threshold value |
| q | output | 9 | Registered read data, tri-state |
| empty | output | 1 | No word held (read domain) |
| full | output | 1 | 512 words held (write domain) |
| half_full | output | 1 | At least 256 words held (write domain) |
| almost_empty | output | 1 | Count at or below threshold (read domain) |
| almost_full | output | 1 | Free space at or below threshold (write domain) |

## Verification
The assertions assume that the rewind request arrives only while both enables are high. They also assume that no more than 512 words were written since the last reset when a rewind is used. A third assumption is that the threshold changes only while both ports are idle, because the read domain samples that register without a synchronizer. The stimulus loads the threshold only between bursts. It holds both enables high during every rewind, and it applies the rewind only after a fresh reset and a short burst. Reset is held long enough for every synchronizer stage to clear.

// File: rtl/retx_fifo_pkg.sv
package retx_fifo_pkg;

    // write-domain status bundle
    typedef struct packed {
        logic full;
        logic half;
        logic near_full;
    } wr_stat_t;

    // read-domain status bundle
    typedef struct packed {
        logic empty;
        logic near_empty;
    } rd_stat_t;

endpackage

// File: rtl/retx_fifo_sync.sv
// Two-stage synchronizer for a Gray pointer, followed by conversion to binary.
module retx_fifo_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stg1, stg2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg1 <= '0;
            stg2 <= '0;
        end else begin
            stg1 <= gray_in;
            stg2 <= stg1;
        end
    end

    always_comb begin
        bin_out[W-1] = stg2[W-1];
        for (int i = W - 2; i >= 0; i--)
            bin_out[i] = bin_out[i+1] ^ stg2[i];
    end
endmodule

// File: rtl/retx_fifo_mem.sv
// Storage array: written on wclk, read through an output register on rclk.
module retx_fifo_mem #(
    parameter int DW = 9,
    parameter int AW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we)
            store[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rst)
            rdata <= '0;
        else if (re)
            rdata <= store[raddr];
    end
endmodule

// File: rtl/retx_fifo_wr.sv
// Write-domain control: write pointer, threshold register and fill flags.
module retx_fifo_wr
    import retx_fifo_pkg::*;
#(
    parameter int AW      = 9,
    parameter int THR_DEF = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en_n,
    input  logic          thr_ld,
    input  logic [AW-1:0] thr_val,
    input  logic [AW:0]   rd_bin_s,
    output logic [AW:0]   wr_bin,
    output logic [AW:0]   wr_gray,
    output logic          we,
    output logic [AW-1:0] thr,
    output wr_stat_t      stat
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] CAP  = {1'b1, {AW{1'b0}}};
    localparam logic [PW-1:0] HALF = {2'b01, {(AW-1){1'b0}}};

    logic [PW-1:0] count, space, wr_nxt;

    assign count = wr_bin - rd_bin_s;
    assign space = CAP - count;

    assign stat.full      = (count == CAP);
    assign stat.half      = (count >= HALF);
    assign stat.near_full = (space <= {1'b0, thr});

    assign we     = !wr_en_n && !stat.full;
    assign wr_nxt = wr_bin + PW'(we);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bin  <= '0;
            wr_gray <= '0;
            thr     <= AW'(THR_DEF);
        end else begin
            wr_bin  <= wr_nxt;
            wr_gray <= wr_nxt ^ (wr_nxt >> 1);
            if (thr_ld)
                thr <= thr_val;
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        stat.full && !wr_en_n |=> $stable(wr_bin));
    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CAP);
    // R1
    wr_gray_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);
    // R4
    full_flags_chk: assert property (@(posedge clk) disable iff (rst)
        stat.full |-> stat.half && stat.near_full);
endmodule

// File: rtl/retx_fifo_rd.sv
// Read-domain control: read pointer, rewind and drain flags.
module retx_fifo_rd
    import retx_fifo_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en_n,
    input  logic          rew_n,
    input  logic [AW-1:0] thr,
    input  logic [AW:0]   wr_bin_s,
    output logic [AW:0]   rd_bin,
    output logic [AW:0]   rd_gray,
    output logic          re,
    output rd_stat_t      stat
);
    localparam int PW = AW + 1;

    logic [PW-1:0] count, rd_nxt;

    assign count           = wr_bin_s - rd_bin;
    assign stat.empty      = (count == '0);
    assign stat.near_empty = (count <= {1'b0, thr});

    assign re = !rd_en_n && !stat.empty && rew_n;

    // the rewind marker is the pointer value left by reset, which is zero
    always_comb begin
        if (!rew_n)
            rd_nxt = '0;
        else
            rd_nxt = rd_bin + PW'(re);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else begin
            rd_bin  <= rd_nxt;
            rd_gray <= rd_nxt ^ (rd_nxt >> 1);
        end
    end

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        stat.empty && rew_n |=> $stable(rd_bin));
    // R7
    rewind_chk: assert property (@(posedge clk) disable iff (rst)
        !rew_n |=> rd_bin == '0);
    // R5
    empty_near_chk: assert property (@(posedge clk) disable iff (rst)
        stat.empty |-> stat.near_empty);
endmodule

// File: rtl/retx_fifo.sv
module retx_fifo
    import retx_fifo_pkg::*;
#(
    parameter int DATA_W  = 9,
    parameter int ADDR_W  = 9,
    parameter int THR_DEF = 64
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_en_n,
    input  logic              rew_n,
    input  logic              out_en,
    input  logic              thr_ld,
    input  logic [ADDR_W-1:0] thr_val,
    output logic [DATA_W-1:0] q,
    output logic              empty,
    output logic              full,
    output logic              half_full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wr_bin, wr_gray, rd_bin, rd_gray, wr_bin_s, rd_bin_s;
    logic              we, re;
    logic [ADDR_W-1:0] thr;
    logic [DATA_W-1:0] q_reg;
    wr_stat_t          wst;
    rd_stat_t          rst_flags;

    retx_fifo_wr #(.AW(ADDR_W), .THR_DEF(THR_DEF)) u_wr (
        .clk(wr_clk), .rst(rst), .wr_en_n(wr_en_n), .thr_ld(thr_ld),
        .thr_val(thr_val), .rd_bin_s(rd_bin_s), .wr_bin(wr_bin),
        .wr_gray(wr_gray), .we(we), .thr(thr), .stat(wst)
    );

    retx_fifo_rd #(.AW(ADDR_W)) u_rd (
        .clk(rd_clk), .rst(rst), .rd_en_n(rd_en_n), .rew_n(rew_n),
        .thr(thr), .wr_bin_s(wr_bin_s), .rd_bin(rd_bin), .rd_gray(rd_gray),
        .re(re), .stat(rst_flags)
    );

    retx_fifo_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst(rst), .gray_in(wr_gray), .bin_out(wr_bin_s)
    );

    retx_fifo_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst(rst), .gray_in(rd_gray), .bin_out(rd_bin_s)
    );

    retx_fifo_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk(wr_clk), .we(we), .waddr(wr_bin[ADDR_W-1:0]), .wdata(din),
        .rclk(rd_clk), .rst(rst), .re(re), .raddr(rd_bin[ADDR_W-1:0]),
        .rdata(q_reg)
    );

    assign q            = out_en ? q_reg : {DATA_W{1'bz}};
    assign empty        = rst_flags.empty;
    assign almost_empty = rst_flags.near_empty;
    assign full         = wst.full;
    assign half_full    = wst.half;
    assign almost_full  = wst.near_full;

    // R8
    hold_q_chk: assert property (@(posedge rd_clk) disable iff (rst)
        !re |=> $stable(q_reg));
endmodule

// File: tb/test_retx_fifo.sv
module test_retx_fifo;
    logic       wr_clk = 0, rd_clk = 0, rst = 1;
    logic       wr_en_n = 1, rd_en_n = 1, rew_n = 1, out_en = 1, thr_ld = 0;
    logic [8:0] din = '0, thr_val = '0;
    tri1  [8:0] q;
    logic       empty, full, half_full, almost_empty, almost_full;

    int checks = 0, errors = 0;
    logic [8:0] hist [$];
    int ridx = 0;
    bit rd_pend = 0;
    string rd_tag = "R1";

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    retx_fifo i_retx_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en_n(wr_en_n),
        .din(din), .rd_en_n(rd_en_n), .rew_n(rew_n), .out_en(out_en),
        .thr_ld(thr_ld), .thr_val(thr_val), .q(q), .empty(empty), .full(full),
        .half_full(half_full), .almost_empty(almost_empty),
        .almost_full(almost_full)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // write monitor: scoreboard push of every accepted word
    always @(negedge wr_clk)
        if (!rst && !wr_en_n && !full) hist.push_back(din);

    // read monitor: compares each read result with the next expected word
    always @(negedge rd_clk) begin
        if (rd_pend) begin
            if (ridx < hist.size()) chk(rd_tag, q, hist[ridx]);
            else chk({rd_tag, " unexpected read"}, q, 9'hxxx);
            ridx++;
        end
        rd_pend = !rst && !rd_en_n && !empty && rew_n;
    end

    task automatic write_burst(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(posedge wr_clk); #1;
            wr_en_n = 0;
            din = 9'(base + i * 7);
        end
        @(posedge wr_clk); #1;
        wr_en_n = 1;
    endtask

    task automatic read_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge rd_clk); #1;
            rd_en_n = 0;
        end
        @(posedge rd_clk); #1;
        rd_en_n = 1;
    endtask

    task automatic rd_wait(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic wr_wait(input int n);
        repeat (n) @(negedge wr_clk);
    endtask

    task automatic do_reset();
        @(posedge rd_clk); #1;
        rst = 1;
        repeat (6) @(posedge rd_clk);
        #1;
        hist.delete();
        ridx = 0;
        rd_pend = 0;
        rst = 0;
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        rd_wait(1);
        // R9 reset state
        chk("R9 empty", 9'(empty), 9'd1);
        chk("R9 full", 9'(full), 9'd0);
        chk("R9 half_full", 9'(half_full), 9'd0);
        chk("R9 almost_empty", 9'(almost_empty), 9'd1);
        chk("R9 almost_full", 9'(almost_full), 9'd0);
        chk("R9 q", q, 9'd0);

        // R7 rewind after a partial read
        write_burst(10, 3);
        rd_wait(6);
        read_burst(4);
        rd_wait(2);
        @(posedge rd_clk); #1; rew_n = 0;
        @(posedge rd_clk); #1; rew_n = 1; ridx = 0; rd_tag = "R7";
        read_burst(10);
        rd_wait(2);
        chk("R7 replay count", 9'(ridx), 9'd10);
        chk("R7 empty after replay", 9'(empty), 9'd1);
        rd_tag = "R1";

        // R2 reads while empty are ignored
        read_burst(3);
        rd_wait(2);
        chk("R2 no read while empty", 9'(ridx), 9'd10);
        write_burst(2, 100);
        rd_wait(6);
        rd_tag = "R2";
        read_burst(2);
        rd_wait(2);
        rd_tag = "R1";

        // fill from a fresh reset
        do_reset();
        write_burst(255, 1);
        wr_wait(1);
        chk("R4 half at 255", 9'(half_full), 9'd0);
        write_burst(1, 50);
        wr_wait(1);
        chk("R4 half at 256", 9'(half_full), 9'd1);
        write_burst(191, 9);
        wr_wait(1);
        chk("R5 almost_full at 447", 9'(almost_full), 9'd0);
        write_burst(1, 77);
        wr_wait(1);
        chk("R5 almost_full at 448", 9'(almost_full), 9'd1);
        write_burst(63, 20);
        wr_wait(1);
        chk("R3 full at 511", 9'(full), 9'd0);
        write_burst(1, 33);
        wr_wait(1);
        chk("R3 full at 512", 9'(full), 9'd1);
        write_burst(3, 200);
        wr_wait(1);
        chk("R2 writes while full dropped", 9'(hist.size()), 9'(512));
        rd_wait(6);
        chk("R5 almost_empty at 512", 9'(almost_empty), 9'd0);
        chk("R3 not empty at 512", 9'(empty), 9'd0);
        rd_tag = "R2";
        read_burst(512);
        rd_tag = "R1";
        rd_wait(2);
        chk("R3 empty after drain", 9'(empty), 9'd1);
        chk("R1 all words read", 9'(ridx), 9'(512));

        // R6 threshold load
        @(posedge wr_clk); #1; thr_ld = 1; thr_val = 9'd20;
        @(posedge wr_clk); #1; thr_ld = 0;
        write_burst(21, 5);
        rd_wait(6);
        chk("R6 almost_empty at 21 thr 20", 9'(almost_empty), 9'd0);
        read_burst(1);
        rd_wait(2);
        chk("R6 almost_empty at 20 thr 20", 9'(almost_empty), 9'd1);
        wr_wait(6);
        chk("R6 almost_full at 20", 9'(almost_full), 9'd0);
        read_burst(20);
        rd_wait(2);

        // R8 output enable and hold
        write_burst(1, 9'h0A5);
        rd_wait(6);
        read_burst(1);
        rd_wait(2);
        out_en = 0;
        #1;
        chk("R8 q floating", q, 9'h1FF);
        out_en = 1;
        rd_wait(4);
        chk("R8 q held", q, 9'h0A5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule